// File: doc/BRIEF.md
# Dual-Direction Command Mailbox

This block carries one-byte commands in both directions between a host bus and a local adapter processor. The host posts a command byte for the adapter, and the adapter posts one for the host. Each command slot has a single occupancy state that both sides can see. The side that receives the command sees it as "full". The side that sent it sees it as "empty", which tells the sender whether it may post again.

A command posted by the host raises a level interrupt toward the adapter CPU. This interrupt is unconditional. A command posted by the adapter raises a level interrupt toward the host, but only when the host's command-interrupt-enable input is high in the cycle of that write. Each interrupt holds until the receiving side strobes a read of the matching slot.

All accesses are single-cycle strobes, with a separate read enable and write enable on each side. The stored bytes are always visible on the read-data outputs. The read strobe marks the command as consumed.

Top module: `cmd_mailbox`

## Requirements
- R1: A host write strobe stores `host_cmd_wdata` in the host-to-adapter slot. In the next cycle `adp_cmd_rdata` shows the byte, `adp_flags` bit 5 (host command full) is 1, and `host_flags` bit 6 (host command empty) is 0.
- R2: A host write strobe drives `adp_irq` high in the next cycle. The level holds while no adapter read occurs, including across further host writes.
- R3: An adapter read strobe, with no host write in the same cycle, clears `adp_flags` bit 5, sets `host_flags` bit 6 and drops `adp_irq` in the next cycle.
- R4: An adapter write strobe stores `adp_cmd_wdata` in the adapter-to-host slot. In the next cycle `host_cmd_rdata` shows the byte, `host_flags` bit 5 (adapter command full) is 1, and `adp_flags` bit 6 (adapter command empty) is 0.
- R5: An adapter write raises `host_irq` only if `host_irq_en` is 1 in the same cycle. Setting `host_irq_en` later does not raise `host_irq` for a command already posted.
- R6: A host read strobe, with no adapter write in the same cycle, sets `adp_flags` bit 6, clears `host_flags` bit 5 and drops `host_irq` in the next cycle.
- R7: While reset is low, both stored bytes are 0x00, both interrupts are low, and both `host_flags` and `adp_flags` equal 0x40 (both slots empty). Reset acts without a clock edge.
- R8: When a write and a read of the same slot occur in one cycle, the write wins. The slot holds the new byte, stays full, and its interrupt is high, provided the host enable is set for the adapter-to-host slot.
- R9: All bits of `host_flags` and `adp_flags` other than bits 5 and 6 read 0.
- R10: The two slots are independent. Accesses on both sides in the same cycle each take effect as if they had happened alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cmd_wr | input | 1 | Host posts a command byte |
| host_cmd_wdata | input | 8 | Command byte from the host |
| host_cmd_rd | input | 1 | Host consumes the adapter's command |
| host_cmd_rdata | output | 8 | Adapter-to-host command byte |
| host_irq_en | input | 1 | Host command-interrupt enable |
| host_flags | output | 8 | Host status view: bit 5 adapter command full, bit 6 host command empty |
| host_irq | output | 1 | Level interrupt toward the host |
| adp_cmd_wr | input | 1 | Adapter posts a command byte |
| adp_cmd_wdata | input | 8 | Command byte from the adapter |
| adp_cmd_rd | input | 1 | Adapter consumes the host's command |
| adp_cmd_rdata | output | 8 | Host-to-adapter command byte |
| adp_flags | output | 8 | Adapter status view: bit 5 host command full, bit 6 adapter command empty |
| adp_irq | output | 1 | Level interrupt toward the adapter CPU |

## Verification
Every result of a strobe (stored byte, both flag views and the interrupt levels) is registered. Each one is therefore due exactly one rising edge after the cycle in which the strobe is driven. The bench drives every vector on a falling edge and samples all outputs on the next falling edge, so each comparison sees the state one edge after its stimulus. Reset is checked shortly after it is asserted, with no clock edge in between, because reset acts asynchronously. The bench then waits out the synchronous release before it drives the next strobe.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int CMD_W     = 8;
  parameter int FLAG_W    = 8;
  parameter int FULL_POS  = 5;
  parameter int EMPTY_POS = 6;
  parameter int SYNC_DEPTH = 2;

  typedef logic [CMD_W-1:0]  cmd_t;
  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[DEPTH-1];
endmodule

// File: rtl/mbox_cmd_slot.sv
module mbox_cmd_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] data,
  output logic         full
);
  logic [W-1:0] data_q, data_d;
  logic         full_q, full_d;
  logic         data_ce;

  // Write wins over a same-cycle read.
  always_comb begin
    data_ce = wr_en;
    data_d  = wr_data;
    full_d  = full_q;
    if (rd_en) full_d = 1'b0;
    if (wr_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (data_ce) data_q <= data_d;
      full_q <= full_d;
    end
  end

  assign data = data_q;
  assign full = full_q;

  // R1 / R4 / R8: a write always leaves the slot full with the written byte
  a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (full && data == $past(wr_data)));

  // R3 / R6: a lone read empties the slot
  a_r3_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> !full);

  // Byte is held when no write happens
  a_r1_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(data));
endmodule

// File: rtl/mbox_irq_hold.sv
module mbox_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic gate,
  input  logic clr_req,
  output logic irq
);
  logic irq_q, irq_d, fire;

  always_comb begin
    fire  = set_req & gate;
    irq_d = irq_q;
    if (clr_req) irq_d = 1'b0;
    if (fire)    irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R5: a rise needs a gated set in the previous cycle
  a_r5_rise_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_req && gate));

  // R3 / R6: a lone clear drops the level
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(set_req && gate)) |=> !irq);

  // R2: level holds without a clear
  a_r2_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq);
endmodule

// File: rtl/mbox_flag_pack.sv
module mbox_flag_pack #(
  parameter int W         = 8,
  parameter int FULL_POS  = 5,
  parameter int EMPTY_POS = 6
) (
  input  logic         full_in,
  input  logic         empty_in,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == FULL_POS) begin : g_full
      assign flags[i] = full_in;
    end else if (i == EMPTY_POS) begin : g_empty
      assign flags[i] = empty_in;
    end else begin : g_zero
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_cmd_wr,
  input  logic [CMD_W-1:0] host_cmd_wdata,
  input  logic             host_cmd_rd,
  output logic [CMD_W-1:0] host_cmd_rdata,
  input  logic             host_irq_en,
  output logic [FLAG_W-1:0] host_flags,
  output logic             host_irq,
  input  logic             adp_cmd_wr,
  input  logic [CMD_W-1:0] adp_cmd_wdata,
  input  logic             adp_cmd_rd,
  output logic [CMD_W-1:0] adp_cmd_rdata,
  output logic [FLAG_W-1:0] adp_flags,
  output logic             adp_irq
);
  logic rst_sync_n;
  logic h2a_full, a2h_full;

  mbox_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_sync_n)
  );

  // host -> adapter slot
  mbox_cmd_slot #(.W(CMD_W)) u_h2a (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(host_cmd_wr), .wr_data(host_cmd_wdata),
    .rd_en(adp_cmd_rd), .data(adp_cmd_rdata), .full(h2a_full)
  );

  // adapter -> host slot
  mbox_cmd_slot #(.W(CMD_W)) u_a2h (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(adp_cmd_wr), .wr_data(adp_cmd_wdata),
    .rd_en(host_cmd_rd), .data(host_cmd_rdata), .full(a2h_full)
  );

  mbox_irq_hold u_adp_irq (
    .clk(clk), .rst_n(rst_sync_n),
    .set_req(host_cmd_wr), .gate(1'b1), .clr_req(adp_cmd_rd), .irq(adp_irq)
  );

  mbox_irq_hold u_host_irq (
    .clk(clk), .rst_n(rst_sync_n),
    .set_req(adp_cmd_wr), .gate(host_irq_en), .clr_req(host_cmd_rd), .irq(host_irq)
  );

  mbox_flag_pack #(.W(FLAG_W), .FULL_POS(FULL_POS), .EMPTY_POS(EMPTY_POS)) u_host_view (
    .full_in(a2h_full), .empty_in(!h2a_full), .flags(host_flags)
  );

  mbox_flag_pack #(.W(FLAG_W), .FULL_POS(FULL_POS), .EMPTY_POS(EMPTY_POS)) u_adp_view (
    .full_in(h2a_full), .empty_in(!a2h_full), .flags(adp_flags)
  );

  // R2: host write raises the adapter interrupt
  a_r2_host_write_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_cmd_wr |=> adp_irq);

  // R5: disabled adapter write leaves an idle host interrupt low
  a_r5_gated_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (adp_cmd_wr && !host_irq_en && !host_irq) |=> !host_irq);

  // R10: host-side write alone leaves the adapter-to-host slot state unchanged
  a_r10_independent: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_cmd_wr && !host_cmd_rd && !adp_cmd_wr) |=> $stable(host_flags[FULL_POS]));

  // R1: adapter interrupt is high whenever the host command slot is reported full
  a_r1_irq_tracks_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adp_irq == adp_flags[FULL_POS]);
endmodule

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       hw; logic [7:0] hd; logic hr;
    logic       aw; logic [7:0] ad; logic ar; logic en;
    logic       e_aint; logic e_hint;
    logic [7:0] e_hfl; logic [7:0] e_afl;
    logic [7:0] e_hdat; logic [7:0] e_adat;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1,8'h3C,0, 0,8'h00,0, 0,  1,0, 8'h00,8'h60, 8'h00,8'h3C, 8'd1},
    '{0,8'h00,0, 0,8'h00,0, 0,  1,0, 8'h00,8'h60, 8'h00,8'h3C, 8'd2},
    '{0,8'h00,0, 0,8'h00,1, 0,  0,0, 8'h40,8'h40, 8'h00,8'h3C, 8'd3},
    '{0,8'h00,0, 1,8'hA5,0, 1,  0,1, 8'h60,8'h00, 8'hA5,8'h3C, 8'd4},
    '{0,8'h00,1, 0,8'h00,0, 0,  0,0, 8'h40,8'h40, 8'hA5,8'h3C, 8'd6},
    '{0,8'h00,0, 1,8'h11,0, 0,  0,0, 8'h60,8'h00, 8'h11,8'h3C, 8'd5},
    '{0,8'h00,0, 0,8'h00,0, 1,  0,0, 8'h60,8'h00, 8'h11,8'h3C, 8'd5},
    '{0,8'h00,1, 0,8'h00,0, 0,  0,0, 8'h40,8'h40, 8'h11,8'h3C, 8'd6},
    '{1,8'h77,0, 0,8'h00,1, 0,  1,0, 8'h00,8'h60, 8'h11,8'h77, 8'd8},
    '{1,8'h88,0, 0,8'h00,0, 0,  1,0, 8'h00,8'h60, 8'h11,8'h88, 8'd2},
    '{1,8'h99,0, 0,8'h00,1, 0,  1,0, 8'h00,8'h60, 8'h11,8'h99, 8'd8},
    '{0,8'h00,0, 0,8'h00,1, 0,  0,0, 8'h40,8'h40, 8'h11,8'h99, 8'd3},
    '{1,8'h5A,0, 1,8'hC3,0, 1,  1,1, 8'h20,8'h20, 8'hC3,8'h5A, 8'd10},
    '{0,8'h00,1, 0,8'h00,1, 0,  0,0, 8'h40,8'h40, 8'hC3,8'h5A, 8'd10},
    '{0,8'h00,1, 1,8'hE1,0, 1,  0,1, 8'h60,8'h00, 8'hE1,8'h5A, 8'd8},
    '{0,8'h00,1, 0,8'h00,0, 0,  0,0, 8'h40,8'h40, 8'hE1,8'h5A, 8'd6}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic host_cmd_wr, host_cmd_rd, host_irq_en, host_irq;
  logic adp_cmd_wr, adp_cmd_rd, adp_irq;
  logic [7:0] host_cmd_wdata, host_cmd_rdata, host_flags;
  logic [7:0] adp_cmd_wdata, adp_cmd_rdata, adp_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_mailbox u_cmd_mailbox (
    .clk(clk), .rst_n(rst_n),
    .host_cmd_wr(host_cmd_wr), .host_cmd_wdata(host_cmd_wdata),
    .host_cmd_rd(host_cmd_rd), .host_cmd_rdata(host_cmd_rdata),
    .host_irq_en(host_irq_en), .host_flags(host_flags), .host_irq(host_irq),
    .adp_cmd_wr(adp_cmd_wr), .adp_cmd_wdata(adp_cmd_wdata),
    .adp_cmd_rd(adp_cmd_rd), .adp_cmd_rdata(adp_cmd_rdata),
    .adp_flags(adp_flags), .adp_irq(adp_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    host_cmd_wr = 0; host_cmd_wdata = 0; host_cmd_rd = 0; host_irq_en = 0;
    adp_cmd_wr = 0; adp_cmd_wdata = 0; adp_cmd_rd = 0;
  endtask

  task automatic check_reset_state(input string tag);
    check({tag, " adp_irq"},  {7'd0, adp_irq},  8'h00);
    check({tag, " host_irq"}, {7'd0, host_irq}, 8'h00);
    check({tag, " host_flags"}, host_flags, 8'h40);
    check({tag, " adp_flags"},  adp_flags,  8'h40);
    check({tag, " host_rdata"}, host_cmd_rdata, 8'h00);
    check({tag, " adp_rdata"},  adp_cmd_rdata,  8'h00);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check_reset_state("R7 power-on");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: drive on falling edge, sample on the next falling edge
    for (int i = 0; i < NV; i++) begin
      host_cmd_wr = TBL[i].hw; host_cmd_wdata = TBL[i].hd; host_cmd_rd = TBL[i].hr;
      adp_cmd_wr  = TBL[i].aw; adp_cmd_wdata  = TBL[i].ad; adp_cmd_rd  = TBL[i].ar;
      host_irq_en = TBL[i].en;
      @(negedge clk);
      check($sformatf("R%0d vec%0d adp_irq", TBL[i].req, i),  {7'd0, adp_irq},  {7'd0, TBL[i].e_aint});
      check($sformatf("R%0d vec%0d host_irq", TBL[i].req, i), {7'd0, host_irq}, {7'd0, TBL[i].e_hint});
      check($sformatf("R%0d vec%0d host_flags", TBL[i].req, i), host_flags, TBL[i].e_hfl);
      check($sformatf("R%0d vec%0d adp_flags", TBL[i].req, i),  adp_flags,  TBL[i].e_afl);
      check($sformatf("R%0d vec%0d host_rdata", TBL[i].req, i), host_cmd_rdata, TBL[i].e_hdat);
      check($sformatf("R%0d vec%0d adp_rdata", TBL[i].req, i),  adp_cmd_rdata,  TBL[i].e_adat);
    end
    idle_inputs();

    // R9: spare flag bits stay zero with both slots full
    host_cmd_wr = 1; host_cmd_wdata = 8'hFF; adp_cmd_wr = 1; adp_cmd_wdata = 8'hFF; host_irq_en = 1;
    @(negedge clk);
    idle_inputs();
    check("R9 host_flags spare bits", host_flags & 8'h9F, 8'h00);
    check("R9 adp_flags spare bits",  adp_flags  & 8'h9F, 8'h00);

    // R7: reset mid-run clears everything without a clock edge
    #2 rst_n = 1'b0;
    #1;
    check_reset_state("R7 mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("R7 after release");

    // R2: interrupt level holds over idle cycles
    host_cmd_wr = 1; host_cmd_wdata = 8'h42;
    @(negedge clk);
    idle_inputs();
    repeat (5) @(negedge clk);
    check("R2 adp_irq held", {7'd0, adp_irq}, 8'h01);
    check("R1 adp_rdata held", adp_cmd_rdata, 8'h42);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule